// File: doc/BRIEF.md
# Request Stream Protocol Monitor

This block sits beside a 512-bit request stream and only observes it; it drives nothing back into the stream. The stream carries valid, ready, data, a keep mask with one bit per 32-bit Dword lane, and last. The monitor tracks where each packet begins and ends. It reports three kinds of sender misbehaviour: valid falling while a packet is open, data or last changing while the receiver stalls, and keep masks that break the contiguity rule.

Any violation marks the packet in flight as bad. When that packet's final beat is accepted, the monitor emits a one-cycle nullify pulse so that downstream logic can discard the request instead of forwarding corrupted data. Each violation class also latches its own sticky cause bit. These bits hold until a synchronous clear.

The packet tracker is a three-state machine. `ST_IDLE` means no packet is open. `ST_BODY` means a packet is open and valid has stayed high. `ST_VOID` means a packet is open and valid has already dropped inside it. The transitions are:

- IDLE→BODY on an accepted beat without last.
- IDLE stays IDLE on an accepted single-beat packet.
- BODY→IDLE and VOID→IDLE on an accepted beat with last.
- BODY→VOID on any cycle with valid low.
- VOID stays in VOID otherwise.

Top module: `rq_stream_monitor`

## Requirements
- R1: After reset, `pkt_err`, `nullify` and all three `err_cause` bits are 0.
- R2: A packet opens on the first accepted beat (valid and ready both high) and closes on the accepted beat with last set. Valid low outside an open packet is not an error, including the cycles between a single-beat packet and the next packet.
- R3: Each cycle with valid low while a packet is open sets `err_cause[0]` (gap) at the next clock edge.
- R4: `nullify` is high for exactly the one cycle after an accepted last beat, and only if a violation was detected between the previous packet's last beat (exclusive) and this last beat (inclusive).
- R5: `pkt_err` rises the cycle after the first violation of a packet. It stays high until the edge that accepts that packet's last beat, and is therefore low whenever `nullify` is high.
- R6: Holding ready low for any number of cycles, with data and last unchanged, causes no error.
- R7: If the previous cycle had valid high and ready low, and the current cycle has valid high with different data or a different last, then `err_cause[1]` (hold) is set at the next edge.
- R8: An accepted beat without last whose keep mask is not all ones sets `err_cause[2]` (keep) at the next edge.
- R9: On an accepted last beat, keep bit i covers Dword lane i. Keep bit 0 must be 1, and no 1 may sit above a 0. Otherwise `err_cause[2]` is set. Legal masks such as 0x000F or 0xFFFF raise nothing.
- R10: Cause bits are sticky. `clr_causes` high zeroes them at the next edge. A violation detected in the same cycle as the clear still sets its own bit.
- R11: A packet with no violation produces neither `pkt_err` nor `nullify`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_causes | input | 1 | Synchronous clear of the sticky cause bits |
| s_valid | input | 1 | Stream valid (observed) |
| s_ready | input | 1 | Stream ready (observed) |
| s_data | input | DATA_W | Stream data (observed) |
| s_keep | input | DATA_W/32 | Per-Dword keep mask (observed) |
| s_last | input | 1 | Final beat marker (observed) |
| pkt_err | output | 1 | Current packet has a detected violation |
| nullify | output | 1 | One-cycle pulse: discard the packet that just ended |
| err_cause | output | 3 | Sticky causes: bit 0 gap, bit 1 hold, bit 2 keep |

## Verification
The bench targets the corner cases where packet boundaries and errors interact:

- **Gap after a single-beat packet.** A monitor that opened a packet on a single-beat transfer would flag a false gap here.
- **Gap inside a packet.** A monitor that missed the packet opening would let a corrupted request go out without a nullify pulse.
- **Stall with stable contents, then a change.** A stall followed by a change in data, and separately in last, catches a comparator that watches the wrong register or ignores last. Long clean stalls catch one that flags legal back-pressure.
- **Keep masks on the last beat.** Masks with a hole, a missing lane 0, or all zeros separate a true contiguity test from a popcount or a nonzero check.
- **Clear racing a new violation.** A clear issued in the same cycle as a fresh violation catches a clear that wins over a set.

// File: rtl/rqm_pkg.sv
package rqm_pkg;

    // Packet tracker states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_VOID = 2'd2
    } rqm_state_e;

    // Cause bit positions in the sticky vector
    localparam int CAUSE_N    = 3;
    localparam int CAUSE_GAP  = 0;
    localparam int CAUSE_HOLD = 1;
    localparam int CAUSE_KEEP = 2;

endpackage

// File: rtl/rqm_seq_fsm.sv
module rqm_seq_fsm
    import rqm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic ready,
    input  logic last,
    output logic gap_viol,
    output logic pkt_done
);

    rqm_state_e state_q, state_d;
    logic       accept;

    assign accept = valid & ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !last) state_d = ST_BODY;
            ST_BODY: begin
                if (!valid)               state_d = ST_VOID;
                else if (accept && last)  state_d = ST_IDLE;
            end
            ST_VOID: if (accept && last)  state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Outputs: a gap is any idle-valid cycle while a packet is open
    always_comb begin
        gap_viol = (state_q != ST_IDLE) && !valid;
        pkt_done = accept && last;
    end

endmodule

// File: rtl/rqm_hold_chk.sv
module rqm_hold_chk #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              ready,
    input  logic [DATA_W-1:0] data,
    input  logic              last,
    output logic              hold_viol
);

    logic              stall_q;
    logic [DATA_W-1:0] data_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= valid & ~ready;
    end

    always_ff @(posedge clk) begin
        data_q <= data;
        last_q <= last;
    end

    assign hold_viol = stall_q & valid & ((data != data_q) | (last != last_q));

endmodule

// File: rtl/rqm_keep_chk.sv
module rqm_keep_chk #(
    parameter int KEEP_W = 16
) (
    input  logic              valid,
    input  logic              ready,
    input  logic              last,
    input  logic [KEEP_W-1:0] keep,
    output logic              keep_viol
);

    logic [KEEP_W-2:0] rise;
    logic              tail_bad;
    logic              body_bad;

    // A one directly above a zero breaks contiguity
    for (genvar i = 0; i < KEEP_W-1; i++) begin : g_rise
        assign rise[i] = keep[i+1] & ~keep[i];
    end

    assign tail_bad  = ~keep[0] | (|rise);
    assign body_bad  = ~(&keep);
    assign keep_viol = valid & ready & (last ? tail_bad : body_bad);

endmodule

// File: rtl/rq_stream_monitor.sv
module rq_stream_monitor
    import rqm_pkg::*;
#(
    parameter int DATA_W = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_causes,
    input  logic                   s_valid,
    input  logic                   s_ready,
    input  logic [DATA_W-1:0]      s_data,
    input  logic [DATA_W/32-1:0]   s_keep,
    input  logic                   s_last,
    output logic                   pkt_err,
    output logic                   nullify,
    output logic [CAUSE_N-1:0]     err_cause
);

    localparam int KEEP_W = DATA_W / 32;

    logic               gap_viol, hold_viol, keep_viol, pkt_done;
    logic [CAUSE_N-1:0] viol;
    logic               any_viol;

    rqm_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (s_valid),
        .ready    (s_ready),
        .last     (s_last),
        .gap_viol (gap_viol),
        .pkt_done (pkt_done)
    );

    rqm_hold_chk #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (s_valid),
        .ready     (s_ready),
        .data      (s_data),
        .last      (s_last),
        .hold_viol (hold_viol)
    );

    rqm_keep_chk #(.KEEP_W(KEEP_W)) u_keep (
        .valid     (s_valid),
        .ready     (s_ready),
        .last      (s_last),
        .keep      (s_keep),
        .keep_viol (keep_viol)
    );

    always_comb begin
        viol             = '0;
        viol[CAUSE_GAP]  = gap_viol;
        viol[CAUSE_HOLD] = hold_viol;
        viol[CAUSE_KEEP] = keep_viol;
        any_viol         = |viol;
    end

    // Packet verdict and sticky causes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_err   <= 1'b0;
            nullify   <= 1'b0;
            err_cause <= '0;
        end else begin
            nullify   <= pkt_done & (pkt_err | any_viol);
            pkt_err   <= pkt_done ? 1'b0 : (pkt_err | any_viol);
            err_cause <= (clr_causes ? '0 : err_cause) | viol;
        end
    end

endmodule

// File: rtl/rqm_checker.sv
module rqm_checker #(
    parameter int DATA_W = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_causes,
    input logic                 s_valid,
    input logic                 s_ready,
    input logic [DATA_W-1:0]    s_data,
    input logic [DATA_W/32-1:0] s_keep,
    input logic                 s_last,
    input logic                 pkt_err,
    input logic                 nullify,
    input logic [2:0]           err_cause
);

    // Independent open-packet tracker built from the ports
    logic open_c;
    always_ff @(posedge clk) begin
        if (!rst_n)                           open_c <= 1'b0;
        else if (s_valid && s_ready)          open_c <= !s_last;
    end

    p_gap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (open_c && !s_valid) |=> err_cause[0]);

    p_hold_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_valid && !s_ready) && s_valid &&
         (s_data != $past(s_data) || s_last != $past(s_last))) |=> err_cause[1]);

    p_keep_body_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_last && !(&s_keep)) |=> err_cause[2]);

    p_keep_lane0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last && !s_keep[0]) |=> err_cause[2]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_causes |=> ((err_cause & $past(err_cause)) == $past(err_cause)));

    p_nullify_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> $past(s_valid && s_ready && s_last));

    p_err_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> !pkt_err);

endmodule

bind rq_stream_monitor rqm_checker #(.DATA_W(DATA_W)) u_rqm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_causes (clr_causes),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .s_keep     (s_keep),
    .s_last     (s_last),
    .pkt_err    (pkt_err),
    .nullify    (nullify),
    .err_cause  (err_cause)
);

// File: tb/test_rq_stream_monitor.sv
`timescale 1ns/1ps
module test_rq_stream_monitor;

    localparam int DW = 512;
    localparam int KW = DW / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_causes = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic [KW-1:0] s_keep = '0;
    logic          s_last = 1'b0;
    logic          pkt_err;
    logic          nullify;
    logic [2:0]    err_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    rq_stream_monitor #(.DATA_W(DW)) i_rq_stream_monitor (
        .clk(clk), .rst_n(rst_n), .clr_causes(clr_causes),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_keep(s_keep), .s_last(s_last),
        .pkt_err(pkt_err), .nullify(nullify), .err_cause(err_cause)
    );

    function automatic logic [DW-1:0] pat(input logic [31:0] seed);
        return {KW{seed}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle, then sample 2 ns after the edge
    task automatic beat(input logic v, input logic r, input logic [31:0] seed,
                        input logic [KW-1:0] k, input logic l);
        s_valid = v; s_ready = r; s_data = pat(seed); s_keep = k; s_last = l;
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat(1'b0, 1'b1, 32'h0, '0, 1'b0);
    endtask

    task automatic clear_all();
        clr_causes = 1'b1; idle(1); clr_causes = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pkt_err", {31'b0, pkt_err}, 32'd0);
        chk("R1 nullify", {31'b0, nullify}, 32'd0);
        chk("R1 causes", {29'b0, err_cause}, 32'd0);
    endtask

    task automatic t_clean_stalls();
        beat(1'b1, 1'b0, 32'hA1, '1, 1'b0);
        beat(1'b1, 1'b0, 32'hA1, '1, 1'b0);
        beat(1'b1, 1'b1, 32'hA1, '1, 1'b0);
        beat(1'b1, 1'b0, 32'hA2, '1, 1'b0);
        beat(1'b1, 1'b0, 32'hA2, '1, 1'b0);
        beat(1'b1, 1'b1, 32'hA2, '1, 1'b0);
        beat(1'b1, 1'b0, 32'hA3, 16'h000F, 1'b1);
        beat(1'b1, 1'b1, 32'hA3, 16'h000F, 1'b1);
        chk("R6 no cause after stalls", {29'b0, err_cause}, 32'd0);
        chk("R11 no nullify clean", {31'b0, nullify}, 32'd0);
        chk("R11 no pkt_err clean", {31'b0, pkt_err}, 32'd0);
    endtask

    task automatic t_gap_outside();
        beat(1'b1, 1'b1, 32'hB0, 16'h0001, 1'b1);
        idle(3);
        beat(1'b1, 1'b1, 32'hB1, '1, 1'b1);
        chk("R2 no gap between packets", {29'b0, err_cause}, 32'd0);
        chk("R2 no nullify", {31'b0, nullify}, 32'd0);
    endtask

    task automatic t_gap_inside();
        beat(1'b1, 1'b1, 32'hC0, '1, 1'b0);
        chk("R5 pkt_err low before gap", {31'b0, pkt_err}, 32'd0);
        beat(1'b0, 1'b1, 32'hC0, '1, 1'b0);
        chk("R3 gap cause", {29'b0, err_cause}, 32'd1);
        chk("R5 pkt_err after gap", {31'b0, pkt_err}, 32'd1);
        chk("R4 no nullify mid packet", {31'b0, nullify}, 32'd0);
        beat(1'b1, 1'b1, 32'hC1, 16'h00FF, 1'b1);
        chk("R4 nullify after last", {31'b0, nullify}, 32'd1);
        chk("R5 pkt_err dropped", {31'b0, pkt_err}, 32'd0);
        idle(1);
        chk("R4 nullify one cycle", {31'b0, nullify}, 32'd0);
        chk("R10 gap cause sticky", {29'b0, err_cause}, 32'd1);
        clear_all();
        chk("R10 clear", {29'b0, err_cause}, 32'd0);
    endtask

    task automatic t_hold();
        beat(1'b1, 1'b0, 32'hD0, '1, 1'b0);
        beat(1'b1, 1'b1, 32'hD5, '1, 1'b0);
        chk("R7 data change in stall", {29'b0, err_cause}, 32'd2);
        beat(1'b1, 1'b1, 32'hD6, '1, 1'b1);
        chk("R4 nullify after hold", {31'b0, nullify}, 32'd1);
        clear_all();
        beat(1'b1, 1'b0, 32'hE0, '1, 1'b0);
        beat(1'b1, 1'b1, 32'hE0, '1, 1'b1);
        chk("R7 last change in stall", {29'b0, err_cause}, 32'd2);
        clear_all();
    endtask

    task automatic t_keep();
        beat(1'b1, 1'b1, 32'hF0, 16'h7FFF, 1'b0);
        chk("R8 partial keep mid packet", {29'b0, err_cause}, 32'd4);
        beat(1'b1, 1'b1, 32'hF1, '1, 1'b1);
        chk("R4 nullify after keep", {31'b0, nullify}, 32'd1);
        clear_all();
        beat(1'b1, 1'b1, 32'hF2, 16'h0005, 1'b1);
        chk("R9 hole in last keep", {29'b0, err_cause}, 32'd4);
        clear_all();
        beat(1'b1, 1'b1, 32'hF3, 16'hFFFE, 1'b1);
        chk("R9 lane0 missing", {29'b0, err_cause}, 32'd4);
        clear_all();
        beat(1'b1, 1'b1, 32'hF4, 16'h0000, 1'b1);
        chk("R9 empty keep", {29'b0, err_cause}, 32'd4);
        clear_all();
        beat(1'b1, 1'b1, 32'hF5, 16'h0FFF, 1'b1);
        chk("R9 legal tail keep", {29'b0, err_cause}, 32'd0);
        chk("R11 legal tail no nullify", {31'b0, nullify}, 32'd0);
    endtask

    task automatic t_clear_race();
        beat(1'b1, 1'b1, 32'h10, 16'h0003, 1'b0);
        chk("R8 set before race", {29'b0, err_cause}, 32'd4);
        beat(1'b1, 1'b0, 32'h11, '1, 1'b0);
        clr_causes = 1'b1;
        beat(1'b1, 1'b1, 32'h12, '1, 1'b1);
        clr_causes = 1'b0;
        chk("R10 set wins over clear", {29'b0, err_cause}, 32'd2);
        idle(2);
        chk("R10 held without clear", {29'b0, err_cause}, 32'd2);
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_clean_stalls();
        t_gap_outside();
        t_gap_inside();
        t_hold();
        t_keep();
        t_clear_race();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule